// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer Pair

This block holds two 8-bit up-counters, an upper and a lower channel. Each channel has two compare registers (A and B), a flag for each compare, a clear-select field, interrupt enables and a waveform output pin. Software programs it through a small register bus. The count strobes come from outside the block as single-cycle tick inputs. A 3-bit clock-select field in each channel picks one of those ticks, stops the channel, or asks for cascading.

Cascading has two forms. If the upper channel selects cascade, the pair becomes one 16-bit counter. The lower channel supplies bits 7:0 and counts its own selected tick. The upper channel supplies bits 15:8 and advances on the carry out of the low byte. In this form the upper channel's flags, clearing and pin follow full 16-bit compares, and the lower channel keeps byte-level flags and pin behaviour. If only the lower channel selects cascade, it counts the compare-A events of the upper channel, and both channels otherwise run on their own.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0, both pins are low and both interrupts are low.
- R2: Clock-select codes 1, 2 and 3 make the counter step by one on `tick_i[0]`, `tick_i[1]` and `tick_i[2]` respectively. Codes 0, 5, 6 and 7 stop the counter. An 8-bit counter wraps from FF to 00.
- R3: A compare event for A (or B) happens on a counting tick that arrives while the count equals compare A (or B). The event sets status bit 0 (A) or bit 1 (B).
- R4: The clear-select field is ctrl bits 4:3. The value 0 never clears. The value 1 loads 0 instead of incrementing on an A event, and the value 2 does the same on a B event. The value 3 clears the counter on each rising edge of `ext_clr_i`; a level held high clears only once.
- R5: A flag clears only when software first reads it as 1 from the status register and then writes 0 to that bit. A write of 0 with no earlier read leaves the flag set. `irq_o[c]` is high while any flag of channel c has its enable set (ctrl bit 5 enables A, ctrl bit 6 enables B).
- R6: The pin register (offset 5) holds the action on A in bits 1:0 and the action on B in bits 3:2. The codes are 0 for no change, 1 for drive low, 2 for drive high and 3 for toggle. When A and B events occur together, the B action applies.
- R7: When the upper clock-select is 4, the pair is one 16-bit counter {upper, lower}. The lower byte steps on the lower channel's selected tick, and the upper byte increments when the lower byte wraps from FF to 00.
- R8: In 16-bit mode the upper flags set only on a 16-bit match against {upper compare, lower compare}. The lower flags set on a byte match against the lower compares.
- R9: In 16-bit mode the upper clear-select clears all 16 bits. The lower clear-select is ignored, and the low byte is never cleared by itself.
- R10: In 16-bit mode the upper pin acts on 16-bit events and the lower pin acts on low-byte events.
- R11: When only the lower clock-select is 4, the lower counter steps once per upper compare-A event. It keeps its own flags, clearing and pin, and its own tick inputs have no effect.
- R12: `bus_addr_i[3]` selects the channel (0 upper, 1 lower), and `bus_addr_i[2:0]` selects the register: 0 ctrl, 1 status, 2 count, 3 compare A, 4 compare B, 5 pin actions. The ctrl layout is clock-select in bits 2:0, clear-select in bits 4:3 and enables in bits 6:5, and bit 7 reads 0. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_addr_i | input | 4 | Channel and register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata_i | input | CW | Write data |
| bus_rdata_o | output | CW | Read data, combinational from the address |
| tick_i | input | NTICK | Count strobes from the prescaler |
| ext_clr_i | input | 1 | External clear, edge-detected |
| irq_o | output | 2 | Interrupt per channel (0 upper, 1 lower) |
| pin_o | output | 2 | Waveform output per channel |

## Verification
The bench drives the 16-bit counter across the FF-to-00 carry, then lands a match that hits the full 16 bits and the low byte in the same tick. A design without the carry, or with a byte-only upper match, would leave the upper byte stuck or set the upper flag too early. It then makes the low byte match alone with the lower clear-select enabled, where a design that honours that field would zero the low byte. Coincident A/B events with opposite pin actions expose a reversed priority. A flag write made before any status read shows whether a design clears flags without the read-then-write sequence. Match-count mode checks that the lower counter steps only on upper A events.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
   localparam logic [2:0] CKS_CASCADE = 3'b100;

   typedef enum logic [1:0] {
      CLR_NONE = 2'b00,
      CLR_MA   = 2'b01,
      CLR_MB   = 2'b10,
      CLR_EXT  = 2'b11
   } clr_sel_e;

   typedef enum logic [1:0] {
      PIN_KEEP   = 2'b00,
      PIN_LOW    = 2'b01,
      PIN_HIGH   = 2'b10,
      PIN_TOGGLE = 2'b11
   } pin_act_e;

   typedef enum logic [2:0] {
      RG_CTRL = 3'd0,
      RG_STAT = 3'd1,
      RG_CNT  = 3'd2,
      RG_CMPA = 3'd3,
      RG_CMPB = 3'd4,
      RG_PIN  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         if (rd_i && flag_o)
            armed_q <= 1'b1;
         else if (wr_i)
            armed_q <= 1'b0;
         // a new event wins over a clear in the same cycle
         if (set_i)
            flag_o <= 1'b1;
         else if (wr_i && !wbit_i && armed_q)
            flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
   import tmr_pair_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       evt_a_i,
   input  logic       evt_b_i,
   input  logic [3:0] act_i,
   output logic       pin_o
);
   function automatic logic apply(logic [1:0] act, logic cur);
      case (pin_act_e'(act))
         PIN_LOW:    return 1'b0;
         PIN_HIGH:   return 1'b1;
         PIN_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pin_o <= 1'b0;
      else if (evt_b_i)
         pin_o <= apply(act_i[3:2], pin_o);
      else if (evt_a_i)
         pin_o <= apply(act_i[1:0], pin_o);
   end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pair_pkg::*;
#(
   parameter int CW    = 8,
   parameter int NTICK = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [3:0]       bus_addr_i,
   input  logic             bus_wr_i,
   input  logic             bus_rd_i,
   input  logic [CW-1:0]    bus_wdata_i,
   output logic [CW-1:0]    bus_rdata_o,
   input  logic [NTICK-1:0] tick_i,
   input  logic             ext_clr_i,
   output logic [1:0]       irq_o,
   output logic [1:0]       pin_o
);
   localparam int NCH = 2;
   localparam int HI  = 0;
   localparam int LO  = 1;
   localparam logic [CW-1:0] CNT_MAX = '1;

   if (CW < 8) begin : g_bad_cw
      $error("tmr_pair: CW must be at least 8 to hold the ctrl fields");
   end
   if (NTICK < 1 || NTICK > 3) begin : g_bad_ntick
      $error("tmr_pair: NTICK must be 1 to 3");
   end

   logic [NCH-1:0][CW-1:0] cnt_q, cmpa_q, cmpb_q;
   logic [NCH-1:0][2:0]    cks_q;
   logic [NCH-1:0][1:0]    clr_q, ien_q, flag;
   logic [NCH-1:0][3:0]    act_q;
   logic [NCH-1:0]         evt_a, evt_b, clr_hit, inc, zap, eq_a, eq_b, itick;
   logic                   ext_q, ext_rise, wide, mcount, tick_lo;
   reg_sel_e               rsel;

   function automatic logic pick_tick(logic [2:0] cks, logic [NTICK-1:0] t);
      logic r;
      r = 1'b0;
      for (int k = 0; k < NTICK; k++)
         if (cks == 3'(k + 1)) r = t[k];
      return r;
   endfunction

   assign rsel     = reg_sel_e'(bus_addr_i[2:0]);
   assign wide     = (cks_q[HI] == CKS_CASCADE);
   assign mcount   = !wide && (cks_q[LO] == CKS_CASCADE);
   assign ext_rise = ext_clr_i && !ext_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ext_q <= 1'b0;
      else         ext_q <= ext_clr_i;
   end

   // count sources and compare events
   assign tick_lo = itick[LO] | (mcount & itick[HI] & eq_a[HI]);

   assign evt_a[LO] = tick_lo & eq_a[LO];
   assign evt_b[LO] = tick_lo & eq_b[LO];
   assign evt_a[HI] = wide ? (tick_lo & eq_a[HI] & eq_a[LO]) : (itick[HI] & eq_a[HI]);
   assign evt_b[HI] = wide ? (tick_lo & eq_b[HI] & eq_b[LO]) : (itick[HI] & eq_b[HI]);

   assign inc[HI] = wide ? (tick_lo & (cnt_q[LO] == CNT_MAX)) : itick[HI];
   assign inc[LO] = tick_lo;
   assign zap[HI] = clr_hit[HI];
   assign zap[LO] = wide ? clr_hit[HI] : clr_hit[LO];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit, wr_ctrl, wr_cnt, wr_cmpa, wr_cmpb, wr_pin, rd_stat, wr_stat;

      assign hit     = (bus_addr_i[3] == 1'(c));
      assign wr_ctrl = bus_wr_i && hit && rsel == RG_CTRL;
      assign wr_cnt  = bus_wr_i && hit && rsel == RG_CNT;
      assign wr_cmpa = bus_wr_i && hit && rsel == RG_CMPA;
      assign wr_cmpb = bus_wr_i && hit && rsel == RG_CMPB;
      assign wr_pin  = bus_wr_i && hit && rsel == RG_PIN;
      assign wr_stat = bus_wr_i && hit && rsel == RG_STAT;
      assign rd_stat = bus_rd_i && hit && rsel == RG_STAT;

      assign itick[c] = pick_tick(cks_q[c], tick_i);
      assign eq_a[c]  = (cnt_q[c] == cmpa_q[c]);
      assign eq_b[c]  = (cnt_q[c] == cmpb_q[c]);
      assign clr_hit[c] = (clr_sel_e'(clr_q[c]) == CLR_MA  && evt_a[c]) ||
                          (clr_sel_e'(clr_q[c]) == CLR_MB  && evt_b[c]) ||
                          (clr_sel_e'(clr_q[c]) == CLR_EXT && ext_rise);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cks_q[c]  <= '0;
            clr_q[c]  <= '0;
            ien_q[c]  <= '0;
            act_q[c]  <= '0;
            cmpa_q[c] <= '0;
            cmpb_q[c] <= '0;
            cnt_q[c]  <= '0;
         end else begin
            if (wr_ctrl) begin
               cks_q[c] <= bus_wdata_i[2:0];
               clr_q[c] <= bus_wdata_i[4:3];
               ien_q[c] <= bus_wdata_i[6:5];
            end
            if (wr_pin)  act_q[c]  <= bus_wdata_i[3:0];
            if (wr_cmpa) cmpa_q[c] <= bus_wdata_i;
            if (wr_cmpb) cmpb_q[c] <= bus_wdata_i;
            if (wr_cnt)       cnt_q[c] <= bus_wdata_i;
            else if (zap[c])  cnt_q[c] <= '0;
            else if (inc[c])  cnt_q[c] <= cnt_q[c] + 1'b1;
         end
      end

      for (genvar b = 0; b < 2; b++) begin : g_flag
         tmr_flag u_flag (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (b == 0 ? evt_a[c] : evt_b[c]),
            .rd_i   (rd_stat),
            .wr_i   (wr_stat),
            .wbit_i (bus_wdata_i[b]),
            .flag_o (flag[c][b])
         );
      end

      tmr_pin u_pin (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .evt_a_i (evt_a[c]),
         .evt_b_i (evt_b[c]),
         .act_i   (act_q[c]),
         .pin_o   (pin_o[c])
      );

      assign irq_o[c] = |(flag[c] & ien_q[c]);
   end

   always_comb begin
      logic ch;
      ch = bus_addr_i[3];
      bus_rdata_o = '0;
      case (rsel)
         RG_CTRL: begin
            bus_rdata_o[2:0] = cks_q[ch];
            bus_rdata_o[4:3] = clr_q[ch];
            bus_rdata_o[6:5] = ien_q[ch];
         end
         RG_STAT: bus_rdata_o[1:0] = flag[ch];
         RG_CNT:  bus_rdata_o      = cnt_q[ch];
         RG_CMPA: bus_rdata_o      = cmpa_q[ch];
         RG_CMPB: bus_rdata_o      = cmpb_q[ch];
         RG_PIN:  bus_rdata_o[3:0] = act_q[ch];
         default: bus_rdata_o      = '0;
      endcase
   end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
   parameter int CW = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               bus_wr_i,
   input logic               ext_clr_i,
   input logic [1:0]         pin_o,
   input logic [1:0]         irq_o,
   input logic [1:0][CW-1:0] cnt_q,
   input logic [1:0]         evt_a,
   input logic [1:0]         evt_b,
   input logic [1:0][1:0]    flag,
   input logic               wide,
   input logic               mcount
);
   localparam logic [CW-1:0] MAXV = '1;

   assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (pin_o == 2'b00 && irq_o == 2'b00));

   assert_hi_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_wr_i |=> (cnt_q[0] == $past(cnt_q[0]) || cnt_q[0] == CW'($past(cnt_q[0]) + 1'b1)
                     || cnt_q[0] == '0));

   assert_lo_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_wr_i |=> (cnt_q[1] == $past(cnt_q[1]) || cnt_q[1] == CW'($past(cnt_q[1]) + 1'b1)
                     || cnt_q[1] == '0));

   assert_irq_has_flag_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[0] |-> (flag[0] != 2'b00));

   assert_irq_has_flag_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[1] |-> (flag[1] != 2'b00));

   assert_pin_quiet_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_a[0] && !evt_b[0]) |=> $stable(pin_o[0]));

   assert_pin_quiet_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_a[1] && !evt_b[1]) |=> $stable(pin_o[1]));

   assert_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wide && !bus_wr_i && cnt_q[1] == MAXV) |=>
         (cnt_q[1] != '0 || cnt_q[0] == CW'($past(cnt_q[0]) + 1'b1) || cnt_q[0] == '0));

   assert_low_byte_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wide && !bus_wr_i && cnt_q[1] != MAXV && cnt_q[1] != '0) |=>
         (cnt_q[1] != '0 || cnt_q[0] == '0));

   assert_mc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mcount && !bus_wr_i && !evt_a[0] && !ext_clr_i) |=> $stable(cnt_q[1]));
endmodule

bind tmr_pair tmr_pair_chk #(.CW(CW)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .bus_wr_i  (bus_wr_i),
   .ext_clr_i (ext_clr_i),
   .pin_o     (pin_o),
   .irq_o     (irq_o),
   .cnt_q     (cnt_q),
   .evt_a     (evt_a),
   .evt_b     (evt_b),
   .flag      (flag),
   .wide      (wide),
   .mcount    (mcount)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
   import tmr_pair_pkg::*;

   localparam int CW = 8;
   localparam int NTICK = 3;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic [3:0]       bus_addr_i = '0;
   logic             bus_wr_i = 1'b0;
   logic             bus_rd_i = 1'b0;
   logic [CW-1:0]    bus_wdata_i = '0;
   logic [CW-1:0]    bus_rdata_o;
   logic [NTICK-1:0] tick_i = '0;
   logic             ext_clr_i = 1'b0;
   logic [1:0]       irq_o, pin_o;

   always #2.5 clk_i = ~clk_i;

   tmr_pair #(.CW(CW), .NTICK(NTICK)) dut_i (
      .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_wdata_i,
      .bus_rdata_o, .tick_i, .ext_clr_i, .irq_o, .pin_o
   );

   typedef struct {
      string       tag;
      int          src;   // 0 read data, 1 pin, 2 irq
      int          idx;
      logic [7:0]  exp;
   } item_t;

   item_t exp_q[$];
   logic  pending = 1'b0;
   int    n_tests = 0;
   int    n_fail = 0;
   logic  done = 1'b0;

   // monitor: pops one expectation per request, away from the active edge
   always @(negedge clk_i) begin
      if (pending && exp_q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = exp_q.pop_front();
         case (it.src)
            0:       act = bus_rdata_o;
            1:       act = {7'd0, pin_o[it.idx]};
            default: act = {7'd0, irq_o[it.idx]};
         endcase
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
         end
         pending = 1'b0;
      end
   end

   task automatic step();
      @(posedge clk_i);
      #1;
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      step();
      step();
      rst_ni = 1'b1;
      step();
   endtask

   task automatic reg_wr(input int ch, input reg_sel_e r, input logic [7:0] d,
                         input logic [NTICK-1:0] tk = '0);
      bus_addr_i  = {ch[0], r};
      bus_wdata_i = d;
      bus_wr_i    = 1'b1;
      tick_i      = tk;
      step();
      bus_wr_i = 1'b0;
      tick_i   = '0;
   endtask

   task automatic tick(input logic [NTICK-1:0] tk, input int n = 1);
      for (int i = 0; i < n; i++) begin
         tick_i = tk;
         step();
         tick_i = '0;
      end
   endtask

   task automatic expect_reg(input int ch, input reg_sel_e r, input logic [7:0] e,
                             input string tag);
      item_t it;
      bus_addr_i = {ch[0], r};
      bus_rd_i   = 1'b1;
      it.tag = tag; it.src = 0; it.idx = 0; it.exp = e;
      exp_q.push_back(it);
      pending = 1'b1;
      wait (pending == 1'b0);
      step();
      bus_rd_i = 1'b0;
   endtask

   task automatic expect_out(input int src, input int idx, input logic e, input string tag);
      item_t it;
      it.tag = tag; it.src = src; it.idx = idx; it.exp = {7'd0, e};
      exp_q.push_back(it);
      pending = 1'b1;
      wait (pending == 1'b0);
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // reset state
      expect_reg(0, RG_CTRL, 8'h00, "R1 ctrl hi");
      expect_reg(1, RG_CNT,  8'h00, "R1 count lo");
      expect_reg(0, RG_STAT, 8'h00, "R1 status hi");
      expect_out(1, 0, 1'b0, "R1 pin hi");
      expect_out(2, 1, 1'b0, "R1 irq lo");
      reg_wr(1, RG_CTRL, 8'hFF);
      expect_reg(1, RG_CTRL, 8'h7F, "R12 ctrl layout readback");

      // independent counting
      do_reset();
      reg_wr(0, RG_CTRL, 8'h01);
      reg_wr(1, RG_CTRL, 8'h02);
      tick(3'b001, 3);
      expect_reg(0, RG_CNT, 8'h03, "R2 tick0 counts");
      tick(3'b011, 2);
      expect_reg(0, RG_CNT, 8'h05, "R2 hi on tick0");
      expect_reg(1, RG_CNT, 8'h02, "R2 lo on tick1");
      tick(3'b100, 1);
      expect_reg(0, RG_CNT, 8'h05, "R2 unselected tick ignored");
      reg_wr(0, RG_CTRL, 8'h05);
      tick(3'b111, 1);
      expect_reg(0, RG_CNT, 8'h05, "R2 code 5 stops");
      expect_reg(1, RG_CNT, 8'h03, "R2 lo still counts");
      reg_wr(0, RG_CTRL, 8'h01);
      reg_wr(0, RG_CNT, 8'hFF);
      tick(3'b001, 1);
      expect_reg(0, RG_CNT, 8'h00, "R2 wrap");
      reg_wr(0, RG_CNT, 8'h20, 3'b001);
      expect_reg(0, RG_CNT, 8'h20, "R12 write beats tick");

      // flags, clears, pins
      do_reset();
      reg_wr(0, RG_CMPA, 8'h03);
      reg_wr(0, RG_CMPB, 8'h05);
      reg_wr(0, RG_PIN,  8'h06);
      reg_wr(0, RG_CTRL, 8'h29);
      tick(3'b001, 4);
      expect_reg(0, RG_CNT, 8'h00, "R4 clear on A");
      expect_out(1, 0, 1'b1, "R6 drive high on A");
      expect_out(2, 0, 1'b1, "R5 irq with enable");
      reg_wr(0, RG_STAT, 8'h00);
      expect_reg(0, RG_STAT, 8'h01, "R5 write without read ignored");
      reg_wr(0, RG_STAT, 8'h00);
      expect_reg(0, RG_STAT, 8'h00, "R5 read then write clears");
      expect_out(2, 0, 1'b0, "R5 irq drops");
      reg_wr(0, RG_CTRL, 8'h11);
      tick(3'b001, 6);
      expect_reg(0, RG_CNT, 8'h00, "R4 clear on B");
      expect_out(1, 0, 1'b0, "R6 drive low on B");
      expect_reg(0, RG_STAT, 8'h03, "R3 both flags");
      expect_out(2, 0, 1'b0, "R5 no irq without enable");
      reg_wr(0, RG_CMPA, 8'h02);
      reg_wr(0, RG_CMPB, 8'h02);
      reg_wr(0, RG_CTRL, 8'h01);
      tick(3'b001, 3);
      expect_out(1, 0, 1'b0, "R6 B wins over A");
      expect_reg(0, RG_CNT, 8'h03, "R4 no clear with code 0");
      reg_wr(0, RG_PIN,  8'h03);
      reg_wr(0, RG_CMPB, 8'h80);
      reg_wr(0, RG_CNT,  8'h00);
      tick(3'b001, 3);
      expect_out(1, 0, 1'b1, "R6 toggle");
      reg_wr(0, RG_CTRL, 8'h19);
      reg_wr(0, RG_CNT,  8'h40);
      ext_clr_i = 1'b1;
      step();
      step();
      expect_reg(0, RG_CNT, 8'h00, "R4 external edge clears");
      tick(3'b001, 1);
      expect_reg(0, RG_CNT, 8'h01, "R4 held level clears once");
      ext_clr_i = 1'b0;

      // 16-bit mode
      do_reset();
      reg_wr(0, RG_CMPA, 8'h01);
      reg_wr(0, RG_CMPB, 8'h77);
      reg_wr(1, RG_CMPA, 8'h02);
      reg_wr(1, RG_CMPB, 8'h77);
      reg_wr(0, RG_PIN,  8'h03);
      reg_wr(1, RG_PIN,  8'h02);
      reg_wr(1, RG_CNT,  8'hFE);
      reg_wr(1, RG_CTRL, 8'h09);
      reg_wr(0, RG_CTRL, 8'h0C);
      tick(3'b001, 2);
      expect_reg(0, RG_CNT, 8'h01, "R7 carry into upper");
      expect_reg(1, RG_CNT, 8'h00, "R7 low byte wrapped");
      tick(3'b001, 3);
      expect_reg(0, RG_CNT, 8'h00, "R9 16-bit clear upper");
      expect_reg(1, RG_CNT, 8'h00, "R9 16-bit clear lower");
      expect_reg(0, RG_STAT, 8'h01, "R8 upper flag on 16-bit match");
      expect_reg(1, RG_STAT, 8'h01, "R8 lower flag on byte match");
      expect_out(1, 0, 1'b1, "R10 upper pin on 16-bit event");
      expect_out(1, 1, 1'b1, "R10 lower pin on byte event");
      reg_wr(0, RG_STAT, 8'h00);
      reg_wr(1, RG_STAT, 8'h00);
      reg_wr(1, RG_PIN,  8'h03);
      tick(3'b001, 3);
      expect_reg(1, RG_CNT, 8'h03, "R9 lower clear-select ignored");
      expect_reg(0, RG_CNT, 8'h00, "R9 upper untouched");
      expect_reg(0, RG_STAT, 8'h00, "R8 no upper flag on byte match");
      expect_reg(1, RG_STAT, 8'h01, "R8 lower flag again");
      expect_out(1, 0, 1'b1, "R10 upper pin unchanged");
      expect_out(1, 1, 1'b0, "R10 lower pin toggled");

      // match-count mode
      do_reset();
      reg_wr(0, RG_CMPA, 8'h01);
      reg_wr(0, RG_CMPB, 8'h55);
      reg_wr(1, RG_CMPA, 8'h55);
      reg_wr(1, RG_CMPB, 8'h55);
      reg_wr(0, RG_CTRL, 8'h09);
      reg_wr(1, RG_CTRL, 8'h04);
      tick(3'b001, 4);
      expect_reg(1, RG_CNT, 8'h02, "R11 counts upper A events");
      expect_reg(0, RG_CNT, 8'h00, "R11 upper clears itself");
      tick(3'b110, 2);
      expect_reg(1, RG_CNT, 8'h02, "R11 own ticks ignored");
      expect_reg(0, RG_STAT, 8'h01, "R11 upper flag own");
      expect_reg(1, RG_STAT, 8'h00, "R11 lower flag own");
      reg_wr(1, RG_CMPA, 8'h02);
      reg_wr(1, RG_CTRL, 8'h0C);
      tick(3'b001, 2);
      expect_reg(1, RG_CNT, 8'h00, "R11 lower own clear");
      expect_reg(1, RG_STAT, 8'h01, "R11 lower flag on its match");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule